// File: doc/BRIEF.md
# Microcontroller Bus Front End with Page Extension

This block sits between a microcontroller's external bus and a set of on-chip memories. It accepts either a shared address/data bus, whose address phase it captures with an address strobe, or separate address and data lines. It turns one of three control-strobe conventions into read, write and code-fetch intent. It prefixes a 4-bit page value to the 16-bit CPU address to form a 20-bit extended address. From that address it drives a one-hot select for eight program-memory windows of 8 KB each, a select for one 2 KB data-RAM window, and two byte-lane enables.

Static configuration inputs set the following:
- bus multiplexing;
- the polarity of the address strobe and of the bus reset;
- the control convention;
- the data width;
- the address of the page register;
- the base of every window.

The page register is loaded by an ordinary CPU write to its configured address. The address capture and the page register are clocked state. The selects and byte enables are combinational from the current pins and that state.

Top module: `mbf_top`

## Requirements
- R1: With `cfg_mux_i`=1 the CPU address is the value of `ad_i` sampled at the most recent rising clock edge at which the address strobe was active. With `cfg_mux_i`=0 it is `addr_i` directly. `ext_addr_o` = {page, CPU address}.
- R2: The address strobe is active when `ale_i` equals `cfg_ale_hi_i`. The captured address does not change at an edge where the strobe is inactive.
- R3: Bus reset is active when `cpu_rst_i` equals `cfg_rst_hi_i`. Bus reset, and `rst_ni` low, each clear the captured address and the page register to 0 at the next edge. While either is active, all selects and `be_o` are 0.
- R4: `cfg_ctl_mode_i` selects the control convention.
  - 0: `rdrw_i` is an active-low read strobe and `strb_i` an active-low write strobe.
  - 1: `strb_i` high enables the access; `rdrw_i` high means read and low means write.
  - 2: `strb_i` low enables the access; `rdrw_i` high means read and low means write.
  - 3: no access.
- R5: `psen_ni` low is a code fetch. A fetch can select program windows but never the RAM window.
- R6: A write whose CPU address equals `cfg_page_addr_i` loads `ad_i[3:0]` into the page register at that clock edge.
- R7: Program window k is hit when `ext_addr_o[19:13]` equals `cfg_blk_base_i[7k+6:7k]`. It is selected on a read or fetch, never on a write.
- R8: The RAM window is hit when `ext_addr_o[19:11]` equals `cfg_ram_base_i`. It is selected on a read or write.
- R9: `blk_sel_o` has at most one bit set, and that bit is the lowest-numbered program window that is hit. `ram_sel_o` is asserted only when no bit of `blk_sel_o` is set.
- R10: With no read, write or fetch active, all selects are 0.
- R11: `be_o` is 0 when no access is active. With `cfg_wide_i`=0 it is 2'b01 on any access. With `cfg_wide_i`=1, bit 0 = !CPU address[0] and bit 1 = !`bhe_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_rst_i | input | 1 | Bus reset pin, polarity set by cfg_rst_hi_i |
| cfg_rst_hi_i | input | 1 | 1: bus reset active high |
| cfg_ale_hi_i | input | 1 | 1: address strobe active high |
| cfg_mux_i | input | 1 | 1: shared address/data bus |
| cfg_wide_i | input | 1 | 1: 16-bit data bus |
| cfg_ctl_mode_i | input | 2 | Control convention |
| cfg_page_addr_i | input | 16 | CPU address of the page register |
| cfg_blk_base_i | input | 56 | Seven-bit base tag per program window |
| cfg_ram_base_i | input | 9 | Base tag of the RAM window |
| ale_i | input | 1 | Address strobe |
| addr_i | input | 16 | Separate address lines |
| ad_i | input | 16 | Shared address/data lines |
| rdrw_i | input | 1 | Read strobe or read/write level |
| strb_i | input | 1 | Write strobe, enable or data strobe |
| psen_ni | input | 1 | Code-fetch strobe, active low |
| bhe_ni | input | 1 | High-byte enable, active low |
| ext_addr_o | output | 20 | Page plus CPU address |
| blk_sel_o | output | 8 | Program window selects |
| ram_sel_o | output | 1 | RAM window select |
| be_o | output | 2 | Byte-lane enables |

## Verification
The selects, byte enables and `ext_addr_o` follow the current strobes and address lines in the same cycle, with no register in between. A captured address or a new page value becomes visible only in the cycle after the edge that stored it. The bench drives all pins just after the falling edge and compares outputs a quarter period later. Its model captures and pages at the rising edge, so each comparison sees exactly the state stored at the preceding edge. Configuration sweeps cover every control mode, both bus styles, both widths and both polarities. Overlapping windows are included to test priority.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
  localparam int unsigned CPU_AW = 16;
  localparam int unsigned PAGE_W = 4;
  localparam int unsigned EXT_AW = CPU_AW + PAGE_W;

  typedef enum logic [1:0] {
    CTL_RDWR  = 2'd0,
    CTL_RW_EN = 2'd1,
    CTL_RW_DS = 2'd2,
    CTL_NONE  = 2'd3
  } ctl_mode_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic fetch;
  } bus_op_t;
endpackage

// File: rtl/mbf_ctl_decode.sv
module mbf_ctl_decode
  import mbf_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       rdrw_i,
  input  logic       strb_i,
  input  logic       psen_ni,
  input  logic       acc_ok_i,
  output bus_op_t    op_o
);
  ctl_mode_e mode;
  logic rd_raw, wr_raw;

  assign mode = ctl_mode_e'(mode_i);

  always_comb begin
    rd_raw = 1'b0;
    wr_raw = 1'b0;
    unique case (mode)
      CTL_RDWR: begin
        rd_raw = !rdrw_i;
        wr_raw = !strb_i;
      end
      CTL_RW_EN: begin
        rd_raw = strb_i && rdrw_i;
        wr_raw = strb_i && !rdrw_i;
      end
      CTL_RW_DS: begin
        rd_raw = !strb_i && rdrw_i;
        wr_raw = !strb_i && !rdrw_i;
      end
      default: begin
        rd_raw = 1'b0;
        wr_raw = 1'b0;
      end
    endcase
  end

  assign op_o.rd    = acc_ok_i && rd_raw;
  assign op_o.wr    = acc_ok_i && wr_raw;
  assign op_o.fetch = acc_ok_i && !psen_ni;
endmodule

// File: rtl/mbf_addr_stage.sv
module mbf_addr_stage
  import mbf_pkg::*;
#(
  parameter int unsigned AW = CPU_AW,
  parameter int unsigned PW = PAGE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  logic          mux_i,
  input  logic          ale_act_i,
  input  logic          wr_i,
  input  logic [AW-1:0] page_addr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] ad_i,
  output logic [AW-1:0] cpu_addr_o,
  output logic [PW-1:0] page_o
);
  logic [AW-1:0] lat_q;
  logic [PW-1:0] page_q;
  logic          page_we;

  assign cpu_addr_o = mux_i ? lat_q : addr_i;
  assign page_we    = wr_i && (cpu_addr_o == page_addr_i);
  assign page_o     = page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= '0;
      page_q <= '0;
    end else if (srst_i) begin
      lat_q  <= '0;
      page_q <= '0;
    end else begin
      if (ale_act_i) lat_q <= ad_i;
      if (page_we)   page_q <= ad_i[PW-1:0];
    end
  end

  assert_latch_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_act_i && !srst_i) |=> $stable(lat_q));

  assert_bus_reset_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (page_q == '0 && lat_q == '0));

  assert_page_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !srst_i && cpu_addr_o == page_addr_i) |=> page_q == $past(ad_i[PW-1:0]));

  assert_page_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !srst_i) |=> $stable(page_q));
endmodule

// File: rtl/mbf_window_match.sv
module mbf_window_match #(
  parameter int unsigned EXT_W     = 20,
  parameter int unsigned NUM_BLK   = 8,
  parameter int unsigned BLK_OFS_W = 13,
  parameter int unsigned RAM_OFS_W = 11,
  localparam int unsigned BLK_TAG_W = EXT_W - BLK_OFS_W,
  localparam int unsigned RAM_TAG_W = EXT_W - RAM_OFS_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [EXT_W-1:0]             ext_addr_i,
  input  logic [NUM_BLK*BLK_TAG_W-1:0] blk_base_i,
  input  logic [RAM_TAG_W-1:0]         ram_base_i,
  input  logic                         pgm_en_i,
  input  logic                         ram_en_i,
  output logic [NUM_BLK-1:0]           blk_sel_o,
  output logic                         ram_sel_o
);
  logic [NUM_BLK-1:0] hit;
  logic [NUM_BLK-1:0] win;
  logic               ram_hit;

  for (genvar k = 0; k < NUM_BLK; k++) begin : g_blk
    assign hit[k] = ext_addr_i[EXT_W-1:BLK_OFS_W] == blk_base_i[k*BLK_TAG_W +: BLK_TAG_W];
  end

  // lowest index wins
  always_comb begin
    win = '0;
    for (int k = NUM_BLK - 1; k >= 0; k--) begin
      if (hit[k]) win = NUM_BLK'(1) << k;
    end
  end

  assign ram_hit   = ext_addr_i[EXT_W-1:RAM_OFS_W] == ram_base_i;
  assign blk_sel_o = pgm_en_i ? win : '0;
  assign ram_sel_o = ram_en_i && ram_hit && (blk_sel_o == '0) && !(pgm_en_i && hit != '0);

  assert_sel_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(blk_sel_o));

  assert_ram_lowest_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_sel_o |-> blk_sel_o == '0);

  assert_sel_is_hit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_sel_o != '0) |-> ((blk_sel_o & hit) == blk_sel_o));
endmodule

// File: rtl/mbf_top.sv
module mbf_top
  import mbf_pkg::*;
#(
  parameter int unsigned NUM_BLK   = 8,
  parameter int unsigned BLK_OFS_W = 13,
  parameter int unsigned RAM_OFS_W = 11,
  localparam int unsigned BLK_TAG_W = EXT_AW - BLK_OFS_W,
  localparam int unsigned RAM_TAG_W = EXT_AW - RAM_OFS_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cpu_rst_i,
  input  logic                         cfg_rst_hi_i,
  input  logic                         cfg_ale_hi_i,
  input  logic                         cfg_mux_i,
  input  logic                         cfg_wide_i,
  input  logic [1:0]                   cfg_ctl_mode_i,
  input  logic [CPU_AW-1:0]            cfg_page_addr_i,
  input  logic [NUM_BLK*BLK_TAG_W-1:0] cfg_blk_base_i,
  input  logic [RAM_TAG_W-1:0]         cfg_ram_base_i,
  input  logic                         ale_i,
  input  logic [CPU_AW-1:0]            addr_i,
  input  logic [CPU_AW-1:0]            ad_i,
  input  logic                         rdrw_i,
  input  logic                         strb_i,
  input  logic                         psen_ni,
  input  logic                         bhe_ni,
  output logic [EXT_AW-1:0]            ext_addr_o,
  output logic [NUM_BLK-1:0]           blk_sel_o,
  output logic                         ram_sel_o,
  output logic [1:0]                   be_o
);
  logic              srst;
  logic              acc_ok;
  bus_op_t           op;
  logic              any_acc;
  logic [CPU_AW-1:0] cpu_addr;
  logic [PAGE_W-1:0] page;

  assign srst   = cpu_rst_i == cfg_rst_hi_i;
  assign acc_ok = rst_ni && !srst;

  mbf_ctl_decode i_ctl (
    .mode_i   (cfg_ctl_mode_i),
    .rdrw_i   (rdrw_i),
    .strb_i   (strb_i),
    .psen_ni  (psen_ni),
    .acc_ok_i (acc_ok),
    .op_o     (op)
  );

  mbf_addr_stage #(.AW(CPU_AW), .PW(PAGE_W)) i_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .srst_i      (srst),
    .mux_i       (cfg_mux_i),
    .ale_act_i   (ale_i == cfg_ale_hi_i),
    .wr_i        (op.wr),
    .page_addr_i (cfg_page_addr_i),
    .addr_i      (addr_i),
    .ad_i        (ad_i),
    .cpu_addr_o  (cpu_addr),
    .page_o      (page)
  );

  assign ext_addr_o = {page, cpu_addr};
  assign any_acc    = op.rd || op.wr || op.fetch;

  mbf_window_match #(
    .EXT_W     (EXT_AW),
    .NUM_BLK   (NUM_BLK),
    .BLK_OFS_W (BLK_OFS_W),
    .RAM_OFS_W (RAM_OFS_W)
  ) i_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_addr_i (ext_addr_o),
    .blk_base_i (cfg_blk_base_i),
    .ram_base_i (cfg_ram_base_i),
    .pgm_en_i   (op.rd || op.fetch),
    .ram_en_i   (op.rd || op.wr),
    .blk_sel_o  (blk_sel_o),
    .ram_sel_o  (ram_sel_o)
  );

  always_comb begin
    be_o = 2'b00;
    if (any_acc) begin
      if (cfg_wide_i) be_o = {!bhe_ni, !cpu_addr[0]};
      else            be_o = 2'b01;
    end
  end

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op.rd && !op.wr && !op.fetch) |-> (blk_sel_o == '0 && !ram_sel_o && be_o == 2'b00));

  assert_reset_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |-> (blk_sel_o == '0 && !ram_sel_o && be_o == 2'b00));

  assert_fetch_no_ram_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op.fetch && !op.rd && !op.wr) |-> !ram_sel_o);

  assert_write_no_blk_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op.wr && !op.rd && !op.fetch) |-> blk_sel_o == '0);

  assert_mode_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_ctl_mode_i == 2'd3) |-> (!op.rd && !op.wr));
endmodule

// File: tb/test_mbf_top.sv
module test_mbf_top;
  localparam time TCK = 20ns;
  localparam logic [15:0] PAGE_ADDR = 16'hFFF0;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_rst_i, cfg_rst_hi_i, cfg_ale_hi_i, cfg_mux_i, cfg_wide_i;
  logic [1:0]  cfg_ctl_mode_i;
  logic [15:0] cfg_page_addr_i;
  logic [55:0] cfg_blk_base_i;
  logic [8:0]  cfg_ram_base_i;
  logic        ale_i, rdrw_i, strb_i, psen_ni, bhe_ni;
  logic [15:0] addr_i, ad_i;
  logic [19:0] ext_addr_o;
  logic [7:0]  blk_sel_o;
  logic        ram_sel_o;
  logic [1:0]  be_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] lat_m;
  logic [3:0]  page_m;

  always #(TCK/2) clk_i = !clk_i;

  mbf_top i_mbf_top (.*);

  function automatic void decode(output bit rd, output bit wr, output bit fe);
    rd = 0; wr = 0;
    case (cfg_ctl_mode_i)
      2'd0: begin rd = !rdrw_i; wr = !strb_i; end
      2'd1: begin rd = strb_i && rdrw_i; wr = strb_i && !rdrw_i; end
      2'd2: begin rd = !strb_i && rdrw_i; wr = !strb_i && !rdrw_i; end
      default: ;
    endcase
    fe = !psen_ni;
  endfunction

  // reference state: capture and page register, updated at the rising edge
  always @(posedge clk_i or negedge rst_ni) begin
    bit rd, wr, fe;
    logic [15:0] cur;
    if (!rst_ni) begin
      lat_m = '0; page_m = '0;
    end else if (cpu_rst_i == cfg_rst_hi_i) begin
      lat_m = '0; page_m = '0;
    end else begin
      decode(rd, wr, fe);
      cur = cfg_mux_i ? lat_m : addr_i;
      if (wr && cur == cfg_page_addr_i) page_m = ad_i[3:0];
      if (ale_i == cfg_ale_hi_i) lat_m = ad_i;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit rd, wr, fe, ok, any;
    logic [15:0] cpu;
    logic [19:0] ext;
    logic [7:0]  eb;
    logic        er;
    logic [1:0]  ebe;
    bit found;
    decode(rd, wr, fe);
    ok  = rst_ni && (cpu_rst_i != cfg_rst_hi_i);
    rd &= ok; wr &= ok; fe &= ok;
    any = rd || wr || fe;
    cpu = cfg_mux_i ? lat_m : addr_i;
    ext = {page_m, cpu};
    eb = '0; found = 0;
    for (int k = 0; k < 8; k++) begin
      if (!found && ext[19:13] == cfg_blk_base_i[k*7 +: 7]) begin
        found = 1;
        if (rd || fe) eb[k] = 1'b1;
      end
    end
    er = (rd || wr) && (ext[19:11] == cfg_ram_base_i) && !(found && (rd || fe));
    ebe = !any ? 2'b00 : (cfg_wide_i ? {!bhe_ni, !cpu[0]} : 2'b01);
    chk("R1 R2 R3 R6 ext_addr", 32'(ext_addr_o), 32'(ext));
    chk(any ? "R4 R5 R7 R9 blk_sel" : "R3 R10 blk_sel", 32'(blk_sel_o), 32'(eb));
    chk(any ? "R4 R5 R8 R9 ram_sel" : "R3 R10 ram_sel", 32'(ram_sel_o), 32'(er));
    chk("R11 be", 32'(be_o), 32'(ebe));
  endtask

  task automatic drive_random(input int phase);
    int r;
    r = $urandom_range(0, 9);
    ale_i   = $urandom_range(0, 1);
    addr_i  = (r < 2) ? PAGE_ADDR : 16'($urandom);
    ad_i    = (r == 3) ? PAGE_ADDR : {16'($urandom) & 16'hFFF3};
    rdrw_i  = $urandom_range(0, 1);
    strb_i  = $urandom_range(0, 1);
    psen_ni = $urandom_range(0, 3) != 0;
    bhe_ni  = $urandom_range(0, 1);
    cpu_rst_i = ($urandom_range(0, 39) == 0) ? cfg_rst_hi_i : !cfg_rst_hi_i;
    if (phase < 0) cpu_rst_i = !cfg_rst_hi_i;
  endtask

  initial begin
    cfg_rst_hi_i = 1; cpu_rst_i = 0; cfg_ale_hi_i = 1; cfg_mux_i = 1; cfg_wide_i = 1;
    cfg_ctl_mode_i = 2'd0; cfg_page_addr_i = PAGE_ADDR;
    for (int k = 0; k < 8; k++) cfg_blk_base_i[k*7 +: 7] = 7'(k * 3);
    cfg_blk_base_i[6*7 +: 7] = 7'd3;   // overlaps window 1
    cfg_ram_base_i = 9'h02A;
    ale_i = 1; addr_i = 16'h1234; ad_i = 16'h5678;
    rdrw_i = 0; strb_i = 0; psen_ni = 0; bhe_ni = 0;
    // R3: reset state with every strobe active
    repeat (2) @(negedge clk_i);
    #(TCK/4);
    chk("R3 reset ext_addr", 32'(ext_addr_o), 32'h0);
    chk("R3 reset blk_sel", 32'(blk_sel_o), 32'h0);
    chk("R3 reset ram_sel", 32'(ram_sel_o), 32'h0);
    chk("R3 reset be", 32'(be_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1;
    for (int ph = 0; ph < 16; ph++) begin
      @(negedge clk_i);
      cfg_ctl_mode_i = ph[1:0];
      cfg_mux_i      = ph[2];
      cfg_wide_i     = ph[3];
      cfg_ale_hi_i   = ph[0] ^ ph[2];
      cfg_rst_hi_i   = ph[1] ^ ph[3];
      cfg_ram_base_i = ph[0] ? 9'h00F : 9'h02A;
      cpu_rst_i      = !cfg_rst_hi_i;
      for (int c = 0; c < 150; c++) begin
        if (c != 0) @(negedge clk_i);
        drive_random(c < 3 ? -1 : ph);
        #(TCK/4);
        compare();
      end
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(TCK * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule